// File: doc/BRIEF.md
# Periodic Refresh Row Address Generator

This block paces DRAM refresh. A programmable interval sets how many clocks pass between refresh requests. A down-counting timer reloads from that interval each time it expires. Every expiry raises a refresh request. The request is held until a downstream memory controller acknowledges it.

Alongside the request, the block presents a row address. The upper part of that address comes from a programmable base register. The lower part comes from a row counter, which steps once for each acknowledged request. The controller can therefore drive this address as the row during a RAS-only refresh cycle, and every request carries a fresh row.

Both programmable values are loaded through a single-cycle write port with a one-bit register select. If a timer expiry arrives while the previous request is still unacknowledged, a sticky overrun flag is raised. The block does not generate memory strobes and does not arbitrate for any bus.

Top module: `refresh_addr_gen`

## Requirements
- R1: After reset the block shows `rfsh_req` = 0, `rfsh_overrun` = 0 and `rfsh_addr` = 0, and the timer is disabled (interval register cleared).
- R2: On a clock edge with `wr_en` = 1, `wr_sel` = 0 loads the interval register from `wr_data[9:0]`, and `wr_sel` = 1 loads the base register from `wr_data[12:0]`.
- R3: With interval N ≥ 1, the first request becomes visible N+1 clock edges after the edge that samples the interval write. Later expiries follow every N+1 clocks.
- R4: With interval 0, the timer never expires, and no request is raised.
- R5: Once raised, `rfsh_req` stays high until an edge samples `rfsh_ack` = 1. An acknowledge that arrives while no request is pending changes nothing at the outputs.
- R6: `rfsh_addr[25:13]` equals the base register and `rfsh_addr[12:0]` equals the row counter.
- R7: The row counter advances by one on each edge where `rfsh_req` and `rfsh_ack` are both high. On every other edge it holds its value.
- R8: The row counter wraps from 8191 to 0.
- R9: An expiry while a request is pending and not being acknowledged sets `rfsh_overrun`, which then stays set until reset.
- R10: An interval write in the middle of a count discards the remaining count and restarts the timer from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the interval register, 1 selects the base register |
| wr_data | input | 16 | Write data |
| rfsh_ack | input | 1 | Acknowledge from the memory controller |
| rfsh_req | output | 1 | Refresh request, held until acknowledged |
| rfsh_addr | output | 26 | Refresh address: base in the upper bits, row in the lower bits |
| rfsh_overrun | output | 1 | Sticky flag for an expiry that hit a pending request |

## Verification
A wrong count in the timer shows up as a wrong request spacing. This is visible on the first request after an interval write, within N+1 clocks. A wrong row counter shows up on `rfsh_addr` at the sample right after an acknowledge. A missed wrap only appears after 8192 acknowledges, so the bench walks the full row space. A lost hold or a missing overrun shows up within one timer period while a request is left pending.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic {
    SEL_IVAL = 1'b0,
    SEL_BASE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/refresh_rst_sync.sv
module refresh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int TMR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ival_we,
  input  logic [TMR_W-1:0] ival_wdata,
  output logic             expire
);
  localparam logic [TMR_W-1:0] ZERO = '0;

  logic [TMR_W-1:0] ival_q, ival_d;
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ival_d = ival_q;
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (ival_we) begin
      ival_d = ival_wdata;
      cnt_d  = ival_wdata;
    end else if (ival_q != ZERO) begin
      if (cnt_q == ZERO) begin
        expire = 1'b1;
        cnt_d  = ival_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q <= ZERO;
      cnt_q  <= ZERO;
    end else begin
      ival_q <= ival_d;
      cnt_q  <= cnt_d;
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ival_q == ZERO) || (cnt_q <= ival_q));

  // R4
  no_expire_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ival_q == ZERO && !ival_we) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack,
  output logic req,
  output logic overrun,
  output logic step
);
  logic req_q, req_d;
  logic ovr_q, ovr_d;

  always_comb begin
    step  = req_q & ack;
    req_d = expire | (req_q & ~ack);
    ovr_d = ovr_q | (expire & req_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      req_q <= req_d;
      ovr_q <= ovr_d;
    end
  end

  assign req     = req_q;
  assign overrun = ovr_q;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack) |=> req_q);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
endmodule

// File: rtl/refresh_rowgen.sv
module refresh_rowgen #(
  parameter int ROW_W  = 13,
  parameter int BASE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [BASE_W-1:0] base_wdata,
  input  logic              step,
  output logic [BASE_W+ROW_W-1:0] addr
);
  logic [ROW_W-1:0]  row_q, row_d;
  logic [BASE_W-1:0] base_q, base_d;

  always_comb begin
    row_d  = row_q;
    base_d = base_q;
    if (step)    row_d  = row_q + 1'b1;
    if (base_we) base_d = base_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      base_q <= '0;
    end else begin
      row_q  <= row_d;
      base_q <= base_d;
    end
  end

  assign addr = {base_q, row_q};

  // R7 R8
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> row_q == ROW_W'($past(row_q) + 1'b1));

  // R7
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(row_q));
endmodule

// File: rtl/refresh_addr_gen.sv
module refresh_addr_gen #(
  parameter int DATA_W = 16,
  parameter int TMR_W  = 10,
  parameter int ROW_W  = 13,
  parameter int BASE_W = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_sel,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    rfsh_ack,
  output logic                    rfsh_req,
  output logic [BASE_W+ROW_W-1:0] rfsh_addr,
  output logic                    rfsh_overrun
);
  import refresh_pkg::*;

  logic rst_int_n;
  logic ival_we, base_we;
  logic expire, step;

  always_comb begin
    ival_we = wr_en & (reg_sel_e'(wr_sel) == SEL_IVAL);
    base_we = wr_en & (reg_sel_e'(wr_sel) == SEL_BASE);
  end

  refresh_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  refresh_timer #(.TMR_W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ival_we    (ival_we),
    .ival_wdata (wr_data[TMR_W-1:0]),
    .expire     (expire)
  );

  refresh_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .expire  (expire),
    .ack     (rfsh_ack),
    .req     (rfsh_req),
    .overrun (rfsh_overrun),
    .step    (step)
  );

  refresh_rowgen #(.ROW_W(ROW_W), .BASE_W(BASE_W)) u_row (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .base_we    (base_we),
    .base_wdata (wr_data[BASE_W-1:0]),
    .step       (step),
    .addr       (rfsh_addr)
  );

  // R5
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!rfsh_req && rfsh_ack && !base_we) |=> $stable(rfsh_addr));
endmodule

// File: tb/tb_refresh_addr_gen.sv
module tb_refresh_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_sel, rfsh_ack;
  logic [15:0] wr_data;
  logic        rfsh_req, rfsh_overrun;
  logic [25:0] rfsh_addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_row  = 0;
  int exp_base = 0;

  always #10 clk = ~clk;

  refresh_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rfsh_ack(rfsh_ack), .rfsh_req(rfsh_req),
    .rfsh_addr(rfsh_addr), .rfsh_overrun(rfsh_overrun)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [25:0] exp_addr();
    return {exp_base[12:0], exp_row[12:0]};
  endfunction

  task automatic wr(input logic sel, input int data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data[15:0];
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!rfsh_req && n < 3000) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  task automatic do_ack();
    rfsh_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    rfsh_ack = 1'b0;
    exp_row = (exp_row + 1) % 8192;
  endtask

  initial begin
    int n;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rfsh_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 req", rfsh_req, 0);
    chk("R1 overrun", rfsh_overrun, 0);
    chk("R1 addr", rfsh_addr, 0);
    repeat (60) @(negedge clk);
    chk("R1 timer disabled", rfsh_req, 0);

    // R5 ack with no request is ignored
    do_ack(); exp_row = 0;
    chk("R5 idle ack addr", rfsh_addr, 0);
    chk("R5 idle ack req", rfsh_req, 0);

    // R4 interval zero never expires
    wr(1'b0, 0);
    repeat (200) @(negedge clk);
    chk("R4 no request", rfsh_req, 0);

    // R2 R3 R6 R7 sweep of intervals and bases
    for (int iv = 2; iv <= 24; iv++) begin
      exp_base = (iv * 613) % 8192;
      wr(1'b1, exp_base + 16'h6000 * (iv % 2));
      chk("R2 R6 base", rfsh_addr, exp_addr());
      wr(1'b0, iv + 16'hFC00 * (iv % 2));
      measure(n);
      chk("R3 period", n, iv + 1);
      chk("R6 addr during req", rfsh_addr, exp_addr());
      do_ack();
      chk("R5 req cleared", rfsh_req, 0);
      chk("R7 row step", rfsh_addr, exp_addr());
    end
    wr(1'b0, 1023);
    measure(n);
    chk("R3 max period", n, 1024);
    do_ack();
    chk("R7 row step max", rfsh_addr, exp_addr());

    // R3 repeat spacing without rewrite
    wr(1'b0, 7);
    measure(n);
    chk("R3 first", n, 8);
    do_ack();
    measure(n);
    chk("R3 repeat", n, 7);
    do_ack();

    // R10 restart on rewrite
    wr(1'b0, 40);
    repeat (10) @(negedge clk);
    chk("R10 no early req", rfsh_req, 0);
    wr(1'b0, 4);
    measure(n);
    chk("R10 restart period", n, 5);
    do_ack();

    // R8 walk the full row space with interval 3
    exp_base = 5;
    wr(1'b1, exp_base);
    wr(1'b0, 3);
    for (int k = 0; k < 8200; k++) begin
      measure(n);
      if (n > 5) chk("R3 walk spacing", n, 4);
      do_ack();
      if (exp_row == 0 || exp_row == 8191 || exp_row == 1)
        chk("R8 wrap", rfsh_addr, exp_addr());
      else if (rfsh_addr != exp_addr())
        chk("R7 walk", rfsh_addr, exp_addr());
    end
    chk("R9 no overrun yet", rfsh_overrun, 0);

    // R9 overrun while pending; R5 hold; R7 address stable
    wr(1'b0, 2);
    measure(n);
    chk("R3 before overrun", n, 3);
    repeat (8) @(negedge clk);
    chk("R5 held", rfsh_req, 1);
    chk("R9 overrun set", rfsh_overrun, 1);
    chk("R7 addr stable", rfsh_addr, exp_addr());
    do_ack();
    wr(1'b0, 0);
    repeat (5) @(negedge clk);
    chk("R9 sticky", rfsh_overrun, 1);
    chk("R7 after ack", rfsh_addr, exp_addr());

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule